// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a bank of general-purpose input pins and raises a single level-sensitive interrupt when any of them toggles. Each pin is first passed through a two-flop synchronizer. The synchronized level is compared with a per-pin stored level. A pin takes part only when it is under general-purpose control and its output driver is off. When such a pin's level differs from the stored copy, the stored copy follows the pin and a sticky change flag for that pin is set.

The flags form a status word. The status word is ANDed with an interrupt mask, and any surviving bit drives the interrupt line. Software sets mask bits with one write strobe and clears them with another, writing 1s in the positions it wants to change. Reading the status word returns the flags gathered so far and clears all of them in the same access. A change that arrives in the very cycle of that read is kept.

Top module: `pin_change_irq`

## Requirements
- R1: After reset the status word, the mask, the stored levels and the interrupt line are all zero.
- R2: A level change on a pin whose control bit is 1 and whose output enable is 0 sets that pin's status bit and copies the new level into the stored level. Both become visible on the third rising clock edge after the pin changes: two synchronizer stages plus one update stage.
- R3: A pin whose output enable is 1 has no effect. Its status bit is not set and its stored level does not change.
- R4: A pin whose control bit is 0, meaning it is handed to a peripheral, has no effect. Its status bit is not set and its stored level does not change.
- R5: A status bit stays set until the status word is read, even if the pin later returns to its earlier level.
- R6: The interrupt output is 1 exactly when at least one bit position has both its status bit and its mask bit set.
- R7: A pulse on the mask-set strobe sets the mask bits where the write data is 1. A pulse on the mask-clear strobe clears the mask bits where the write data is 1. Mask bits where the data is 0 are left alone. If both strobes are pulsed together, clear wins for a bit that has 1 in the data.
- R8: While the read strobe is high, the status output shows the accumulated flags. From the next cycle on, all flags are zero and the interrupt is low, unless R9 applies.
- R9: A change that is detected in the same cycle as a status read is not lost. Its status bit is set after the read, while every older flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| gp_ctl_i | input | NPINS | 1 = pin under general-purpose control |
| out_en_i | input | NPINS | 1 = pin driven as an output |
| mask_set_i | input | 1 | Strobe: set mask bits where wdata_i is 1 |
| mask_clr_i | input | 1 | Strobe: clear mask bits where wdata_i is 1 |
| wdata_i | input | NPINS | Write data for the mask strobes |
| status_rd_i | input | 1 | Status read strobe; clears the flags |
| level_o | output | NPINS | Stored pin levels |
| status_o | output | NPINS | Status word of change flags |
| mask_o | output | NPINS | Interrupt mask |
| irq_o | output | 1 | Level-sensitive interrupt |

## Verification
The bench times a read so that it lands in exactly the cycle in which a fresh change is detected. A design that cleared the whole word unconditionally would lose that change, and one that skipped the clear would keep the stale flag. It toggles pins that are driven as outputs and pins handed to a peripheral. A design that qualified only one of the two conditions would raise a flag or move the stored level for the other kind of pin. It also pulses both mask strobes together, and checks that a flag survives its pin returning to the old level. Swapping the priority of the strobes, or making the flag follow the pin instead of sticking, would each show up as a mismatch.

// File: rtl/pin_change_irq.sv
module pin_change_irq #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] gp_ctl_i,
  input  logic [NPINS-1:0] out_en_i,
  input  logic             mask_set_i,
  input  logic             mask_clr_i,
  input  logic [NPINS-1:0] wdata_i,
  input  logic             status_rd_i,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] status_o,
  output logic [NPINS-1:0] mask_o,
  output logic             irq_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NPINS-1:0] sync_q [SYNC_STAGES];
  logic [NPINS-1:0] level_q, status_q, mask_q;
  logic [NPINS-1:0] watch, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  assign watch = gp_ctl_i & ~out_en_i;
  assign hit   = watch & (sync_q[LAST] ^ level_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      level_q  <= level_q ^ hit;
      status_q <= (status_rd_i ? '0 : status_q) | hit;
      mask_q   <= (mask_q | (wdata_i & {NPINS{mask_set_i}}))
                  & ~(wdata_i & {NPINS{mask_clr_i}});
    end
  end

  assign level_o  = level_q;
  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  a_r3_oe_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((level_q ^ $past(level_q)) & $past(out_en_i)) == '0));

  a_r4_periph_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((level_q ^ $past(level_q)) & ~$past(gp_ctl_i)) == '0));

  a_r2_level_move_flags: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((level_q ^ $past(level_q)) & ~status_q) == '0));

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_i |=> ((status_q & ~$past(hit)) == '0));

  a_r9_keep_new: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_i |=> ((status_q & $past(hit)) == $past(hit)));

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clr_i |=> ((mask_q & $past(wdata_i)) == '0));

  a_r6_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd_i |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin = '0, gp = '0, oe = '0, wdata = '0;
  logic mset = 0, mclr = 0, rd = 0;
  logic [N-1:0] level, status, mask;
  logic irq;

  int checks = 0, fails = 0;
  logic [N-1:0] exp_level = '0, exp_status = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_change_irq #(.NPINS(N), .SYNC_STAGES(2)) u_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .gp_ctl_i(gp), .out_en_i(oe),
    .mask_set_i(mset), .mask_clr_i(mclr), .wdata_i(wdata),
    .status_rd_i(rd), .level_o(level), .status_o(status), .mask_o(mask),
    .irq_o(irq));

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // reference update from the requirements, applied once pins are stable
  task automatic model();
    logic [N-1:0] nf;
    nf = gp & ~oe & (pin ^ exp_level);
    exp_level  = exp_level ^ nf;
    exp_status = exp_status | nf;
  endtask

  task automatic read_status(output logic [N-1:0] got);
    rd = 1;
    #1 got = status;
    tick(1);
    rd = 0;
  endtask

  task automatic mask_write(logic s, logic c, logic [N-1:0] v);
    mset = s; mclr = c; wdata = v;
    tick(1);
    mset = 0; mclr = 0; wdata = '0;
  endtask

  task automatic settle();
    logic [N-1:0] g;
    tick(4);
    model();
    read_status(g);
    exp_status = '0;
  endtask

  task automatic t_reset();
    check("R1 status", status, '0);
    check("R1 mask", mask, '0);
    check("R1 level", level, '0);
    check("R1 irq", {31'b0, irq}, '0);
  endtask

  task automatic t_basic();
    logic [N-1:0] g;
    gp = '1; oe = '0;
    pin = 32'h0000_00A5;
    tick(2);
    check("R2 latency", status, '0);
    tick(1);
    model();
    check("R2 status", status, exp_status);
    check("R2 level", level, exp_level);
    read_status(g);
    check("R8 read value", g, 32'h0000_00A5);
    exp_status = '0;
    check("R8 cleared", status, '0);
    pin = 32'hFFFF_0000 ^ pin;
    tick(3);
    model();
    check("R2 many pins status", status, 32'hFFFF_0000);
    check("R2 many pins level", level, 32'hFFFF_00A5);
    settle();
  endtask

  task automatic t_oe();
    oe = 32'h0000_FF00;
    pin = pin ^ 32'h0000_0F0F;
    tick(3);
    model();
    check("R3 status", status, 32'h0000_000F);
    check("R3 level", level, exp_level);
    oe = '0;
    settle();
  endtask

  task automatic t_periph();
    gp = ~32'h00FF_0000;
    pin = pin ^ 32'h0011_0001;
    tick(3);
    model();
    check("R4 status", status, 32'h0000_0001);
    check("R4 level", level, exp_level);
    gp = '1;
    settle();
  endtask

  task automatic t_sticky();
    pin = pin ^ 32'h8;
    tick(3);
    pin = pin ^ 32'h8;
    tick(3);
    model();
    check("R5 sticky after return", status, 32'h8);
    tick(10);
    check("R5 sticky later", status, 32'h8);
  endtask

  task automatic t_mask();
    logic [N-1:0] g;
    check("R6 unmasked irq low", {31'b0, irq}, '0);
    mask_write(1, 0, 32'h10);
    check("R7 set", mask, 32'h10);
    check("R6 other bit masked", {31'b0, irq}, '0);
    mask_write(1, 0, 32'h08);
    check("R7 set keeps", mask, 32'h18);
    check("R6 irq high", {31'b0, irq}, 32'h1);
    mask_write(0, 1, 32'h10);
    check("R7 clear", mask, 32'h08);
    check("R6 irq stays", {31'b0, irq}, 32'h1);
    mask_write(1, 1, 32'h08);
    check("R7 clear wins", mask, '0);
    check("R6 irq low", {31'b0, irq}, '0);
    mask_write(1, 0, '1);
    check("R6 irq all mask", {31'b0, irq}, 32'h1);
    read_status(g);
    exp_status = '0;
    check("R8 read value", g, 32'h8);
    check("R8 irq low after read", {31'b0, irq}, '0);
  endtask

  task automatic t_collide();
    logic [N-1:0] g;
    pin = pin ^ 32'h20;
    tick(4);
    model();
    check("R9 old flag", status, 32'h20);
    pin = pin ^ 32'h40;
    tick(2);
    rd = 1;
    #1 g = status;
    tick(1);
    rd = 0;
    check("R9 read value", g, 32'h20);
    check("R9 new flag kept", status, 32'h40);
    check("R9 irq from new flag", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_basic();
    t_oe();
    t_periph();
    t_sticky();
    t_mask();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule